// File: doc/BRIEF.md
# Three-Class Fixed-Weight Perceptron Scorer

This block scores one four-element signed feature vector against three classes whose weights are fixed in the design. A host writes the four features into a small local buffer through an indexed write port. It then pulses a start input. The block walks the features in index order. Three multiply-accumulate lanes, one per class, each read their own constant weight table, so all three lanes advance on the same feature in the same cycle.

Each feature takes two cycles. In the first, the lanes capture the feature and their weights into operand registers. In the second, each lane adds the product into a 16-bit accumulator that wraps modulo 2^16. After the last feature, the three accumulators are copied to the score output, and a single-cycle done pulse marks them valid. The feature buffer keeps its contents between runs, so the same vector can be scored again without writing it a second time.

Top module: `tri_class_scorer`

## Requirements
- R1: After reset, `busy` and `done` are 0 and all score fields are 0.
- R2: A write with `feat_wr` high stores `feat_data` into feature slot `feat_idx` (0 to 3) at the clock edge. A write while `busy` is high is ignored and changes no score.
- R3: A `start` pulse sampled while `busy` is low begins a run, and `busy` reads 1 in the next cycle. A `start` sampled while `busy` is high is ignored and does not restart or stretch the run.
- R4: `done` is high for exactly one cycle and rises at the 9th clock edge after the edge that accepted `start`. `busy` is high for the 9 cycles before that, and `busy` is 0 while `done` is 1.
- R5: Score field 0 (`scores[15:0]`) equals -9*f0 + 25*f1 - 28*f2 - 27*f3, where fN is the signed feature in slot N.
- R6: Score field 1 (`scores[31:16]`) equals -3*f0 - 31*f1 + 58*f2 - 31*f3.
- R7: Score field 2 (`scores[47:32]`) equals -10*f0 + 4*f1 + 80*f2 + 79*f3.
- R8: When the exact sum falls outside the signed 16-bit range, each score equals the exact sum reduced modulo 2^16, read as two's complement.
- R9: The score outputs change only in a cycle where `done` is 1, and otherwise hold their last value.
- R10: The feature buffer keeps its values across runs. A second start with no new writes reproduces the same scores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_wr | input | 1 | Feature buffer write strobe |
| feat_idx | input | 2 | Feature slot to write |
| feat_data | input | 16 | Signed feature value to write |
| start | input | 1 | One-cycle request to begin scoring |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when the scores are updated |
| scores | output | 48 | Three signed 16-bit scores; class c at bits [16c+15:16c] |

## Verification
The bench sweeps all four features over the extreme and unit values -32768, -1, 0, 1 and 32767. This covers sign handling, zero suppression and accumulator wrap. A lane that sign-extended wrongly, saturated instead of wrapping, or paired a weight with the wrong feature slot would give a wrong score on some vector. A run that cleared its accumulators late would carry the previous result into the next one. Directed runs pulse `start` and write the buffer in the middle of a run. A design that restarted, stretched the run, or let the write reach the operand path would move the `done` edge or change the result. A repeated run with no new writes exposes a buffer that loses its contents.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_MAC   = 2'd2,
      ST_EMIT  = 2'd3
   } tcs_state_e;

   // Fixed class weights, selected by class and feature slot.
   function automatic int tcs_weight(input int cls, input int slot);
      int w;
      w = 0;
      case (cls)
         0: case (slot)
               0: w = -9;
               1: w = 25;
               2: w = -28;
               3: w = -27;
               default: w = 0;
            endcase
         1: case (slot)
               0: w = -3;
               1: w = -31;
               2: w = 58;
               3: w = -31;
               default: w = 0;
            endcase
         2: case (slot)
               0: w = -10;
               1: w = 4;
               2: w = 80;
               3: w = 79;
               default: w = 0;
            endcase
         default: w = 0;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/tcs_feat_buf.sv
module tcs_feat_buf #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 4,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q[g] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            slot_q[g] <= wr_data;
         end
      end
   end

   assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/tcs_weight_rom.sv
module tcs_weight_rom
   import tcs_pkg::*;
#(
   parameter int CLASS  = 0,
   parameter int DEPTH  = 4,
   parameter int COEF_W = 16,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [COEF_W-1:0] weight
);

   logic [COEF_W-1:0] wtab [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      assign wtab[g] = COEF_W'(tcs_weight(CLASS, g));
   end

   assign weight = wtab[rd_idx];

endmodule

// File: rtl/tcs_mac_lane.sv
module tcs_mac_lane #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              mac,
   input  logic [DATA_W-1:0] feat,
   input  logic [DATA_W-1:0] weight,
   output logic [DATA_W-1:0] acc
);

   logic [DATA_W-1:0] feat_q;
   logic [DATA_W-1:0] wt_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] prod_lo;

   // The low DATA_W bits of a two's complement product depend only on the
   // low DATA_W bits of the operands, so a truncated multiply is exact
   // modulo 2^DATA_W.
   assign prod_lo = feat_q * wt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         feat_q <= '0;
         wt_q   <= '0;
         acc_q  <= '0;
      end else begin
         if (load) begin
            feat_q <= feat;
            wt_q   <= weight;
         end
         if (clr) begin
            acc_q <= '0;
         end else if (mac) begin
            acc_q <= acc_q + prod_lo;
         end
      end
   end

   assign acc = acc_q;

endmodule

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
   import tcs_pkg::*;
#(
   parameter int NUM_FEAT = 4,
   parameter int IDX_W    = $clog2(NUM_FEAT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             clr,
   output logic             load,
   output logic             mac,
   output logic             emit,
   output logic [IDX_W-1:0] idx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FEAT - 1);

   tcs_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_FETCH;
                  idx_q   <= '0;
               end
            end
            ST_FETCH: state_q <= ST_MAC;
            ST_MAC: begin
               if (idx_q == LAST) begin
                  state_q <= ST_EMIT;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_FETCH;
               end
            end
            ST_EMIT: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign clr  = (state_q == ST_IDLE) && start;
   assign load = (state_q == ST_FETCH);
   assign mac  = (state_q == ST_MAC);
   assign emit = (state_q == ST_EMIT);
   assign idx  = idx_q;

endmodule

// File: rtl/tri_class_scorer.sv
module tri_class_scorer #(
   parameter int DATA_W    = 16,
   parameter int NUM_FEAT  = 4,
   parameter int NUM_CLASS = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          feat_wr,
   input  logic [$clog2(NUM_FEAT)-1:0]   feat_idx,
   input  logic [DATA_W-1:0]             feat_data,
   input  logic                          start,
   output logic                          busy,
   output logic                          done,
   output logic [NUM_CLASS*DATA_W-1:0]   scores
);

   localparam int IDX_W   = $clog2(NUM_FEAT);
   localparam int SCORE_W = NUM_CLASS * DATA_W;

   // Elaboration-time checks: the weight tables cover exactly this shape.
   if (NUM_FEAT != 4) begin : g_bad_feat
      $error("tri_class_scorer: NUM_FEAT must be 4");
   end
   if (NUM_CLASS != 3) begin : g_bad_class
      $error("tri_class_scorer: NUM_CLASS must be 3");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("tri_class_scorer: DATA_W must hold the largest weight");
   end

   logic              run_busy;
   logic              lane_clr;
   logic              lane_load;
   logic              lane_mac;
   logic              emit;
   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] feat_rd;
   logic [SCORE_W-1:0] acc_all;
   logic [SCORE_W-1:0] score_q;
   logic               done_q;

   tcs_ctrl #(
      .NUM_FEAT (NUM_FEAT),
      .IDX_W    (IDX_W)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (run_busy),
      .clr   (lane_clr),
      .load  (lane_load),
      .mac   (lane_mac),
      .emit  (emit),
      .idx   (rd_idx)
   );

   tcs_feat_buf #(
      .DATA_W (DATA_W),
      .DEPTH  (NUM_FEAT),
      .IDX_W  (IDX_W)
   ) u_fbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (feat_wr && !run_busy),
      .wr_idx  (feat_idx),
      .wr_data (feat_data),
      .rd_idx  (rd_idx),
      .rd_data (feat_rd)
   );

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_lane
      logic [DATA_W-1:0] wt;
      logic [DATA_W-1:0] acc;

      tcs_weight_rom #(
         .CLASS  (c),
         .DEPTH  (NUM_FEAT),
         .COEF_W (DATA_W),
         .IDX_W  (IDX_W)
      ) u_rom (
         .rd_idx (rd_idx),
         .weight (wt)
      );

      tcs_mac_lane #(
         .DATA_W (DATA_W)
      ) u_mac (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (lane_clr),
         .load   (lane_load),
         .mac    (lane_mac),
         .feat   (feat_rd),
         .weight (wt),
         .acc    (acc)
      );

      assign acc_all[c*DATA_W +: DATA_W] = acc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         score_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= emit;
         if (emit) begin
            score_q <= acc_all;
         end
      end
   end

   assign busy   = run_busy;
   assign done   = done_q;
   assign scores = score_q;

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
   parameter int DATA_W    = 16,
   parameter int NUM_FEAT  = 4,
   parameter int NUM_CLASS = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        start,
   input logic                        busy,
   input logic                        done,
   input logic [NUM_CLASS*DATA_W-1:0] scores
);

   localparam int RUN_LEN = 2 * NUM_FEAT + 1;
   localparam int CNT_W   = $clog2(RUN_LEN + 1) + 1;

   logic [CNT_W-1:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_cnt <= '0;
      end else if (busy) begin
         busy_cnt <= busy_cnt + 1'b1;
      end else begin
         busy_cnt <= '0;
      end
   end

   p_start_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (busy_cnt < CNT_W'(RUN_LEN - 1))) |=> busy);

   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_run_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_cnt == CNT_W'(RUN_LEN)));

   p_scores_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scores) |-> done);

endmodule

bind tri_class_scorer tcs_checker #(
   .DATA_W    (DATA_W),
   .NUM_FEAT  (NUM_FEAT),
   .NUM_CLASS (NUM_CLASS)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .scores (scores)
);

// File: tb/tri_class_scorer_test.sv
`timescale 1ns/100ps
module tri_class_scorer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        feat_wr = 1'b0;
   logic [1:0]  feat_idx = '0;
   logic [15:0] feat_data = '0;
   logic        start = 1'b0;
   logic        busy;
   logic        done;
   logic [47:0] scores;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int model_f [4];

   always #2.5 clk = ~clk;

   tri_class_scorer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .feat_wr   (feat_wr),
      .feat_idx  (feat_idx),
      .feat_data (feat_data),
      .start     (start),
      .busy      (busy),
      .done      (done),
      .scores    (scores)
   );

   function automatic int wgt(input int c, input int i);
      int a0 [4] = '{-9, 25, -28, -27};
      int a1 [4] = '{-3, -31, 58, -31};
      int a2 [4] = '{-10, 4, 80, 79};
      if (c == 0) return a0[i];
      if (c == 1) return a1[i];
      return a2[i];
   endfunction

   function automatic int exact_sum(input int c);
      int s = 0;
      for (int i = 0; i < 4; i++) s += wgt(c, i) * model_f[i];
      return s;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_feat(input int i, input int v);
      @(negedge clk);
      feat_wr   = 1'b1;
      feat_idx  = 2'(i);
      feat_data = 16'(v);
      @(negedge clk);
      feat_wr = 1'b0;
      model_f[i] = int'($signed(16'(v)));
   endtask

   task automatic check_scores();
      for (int c = 0; c < 3; c++) begin
         int s = exact_sum(c);
         logic signed [15:0] e = 16'(s);
         logic signed [15:0] a = scores[c*16 +: 16];
         if (s > 32767 || s < -32768) check("R8 wrapped score", int'(a), int'(e));
         else if (c == 0) check("R5 class0 score", int'(a), int'(e));
         else if (c == 1) check("R6 class1 score", int'(a), int'(e));
         else check("R7 class2 score", int'(a), int'(e));
      end
   endtask

   // disturb: pulse start and write the buffer in the middle of the run
   task automatic run(input bit disturb);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R3 busy after start", int'(busy), 1);
      for (int k = 1; k <= 9; k++) begin
         if (disturb && k == 3) start = 1'b1;
         if (disturb && k == 4) begin
            start     = 1'b0;
            feat_wr   = 1'b1;
            feat_idx  = 2'd2;
            feat_data = 16'h3039;
         end
         if (disturb && k == 5) feat_wr = 1'b0;
         @(negedge clk);
         if (k < 9) begin
            if (done !== 1'b0) check("R4 done early", int'(done), 0);
            if (busy !== 1'b1) check("R3 busy held", int'(busy), 1);
         end
      end
      check("R4 done at 9th edge", int'(done), 1);
      check("R4 busy low with done", int'(busy), 0);
      check_scores();
      @(negedge clk);
      check("R4 done one cycle", int'(done), 0);
      check_scores();  // R9: scores held after done
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         errors++;
         $display("FAIL R4 watchdog actual=%0d expected=<190000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int vals [5] = '{-32768, -1, 0, 1, 32767};
      for (int i = 0; i < 4; i++) model_f[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy reset", int'(busy), 0);
      check("R1 done reset", int'(done), 0);
      check("R1 scores reset", int'(scores == 48'd0), 1);

      // R2 unit vectors pick out each weight column
      for (int j = 0; j < 4; j++) begin
         for (int i = 0; i < 4; i++) write_feat(i, (i == j) ? 1 : 0);
         run(1'b0);
      end

      // R10 rerun with no writes; then R2 and R3 disturbance during a run
      write_feat(0, 1000); write_feat(1, -2000);
      write_feat(2, 3000); write_feat(3, -4000);
      run(1'b0);
      run(1'b0);
      run(1'b1);
      run(1'b0);  // R2: ignored write left slot 2 unchanged

      // Near-exhaustive sweep over extreme values (R5..R8)
      for (int a = 0; a < 5; a++)
         for (int b = 0; b < 5; b++)
            for (int c = 0; c < 5; c++)
               for (int d = 0; d < 5; d++) begin
                  write_feat(0, vals[a]); write_feat(1, vals[b]);
                  write_feat(2, vals[c]); write_feat(3, vals[d]);
                  run(1'b0);
               end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule